// File: doc/BRIEF.md
# Dual Pulse Up/Down Counter

This block is a small binary counter with two count inputs. A rising edge on one input adds one to the count. A rising edge on the other input subtracts one. The count wraps around in both directions. An active-low load control copies a parallel data word into the counter. An active-high master reset clears the counter at once and overrides every other control.

Two active-low terminal outputs let stages be chained. The carry output goes low while the count is at its maximum and the up input is low. The borrow output goes low while the count is zero and the down input is low. When the next stage takes these outputs as its own count inputs, the wrapping edge of this stage reaches it as a rising edge.

The whole block runs on one free-running system clock. Each count input passes through a synchronizer, and an edge detector turns it into a single-cycle step request. This suits count pulses that come from a slower or unrelated source.

Top module: `dual_pulse_counter`

## Requirements
- R1: While `mreset` is high, `count` is 0 without waiting for a clock edge. Reset overrides load and counting.
- R2: A low-to-high change on `up` that stays stable for at least one clock period increments `count` by one. The change takes effect at the third rising `clk` edge that samples `up` high.
- R3: A low-to-high change on `down` decrements `count` by one, with the same three-edge latency as R2.
- R4: Counting up from the maximum value (15 at the default width) gives 0.
- R5: Counting down from 0 gives the maximum value.
- R6: When `load_n` is sampled low on a clock edge, `count` takes the value of `data` at that edge. While `load_n` stays low, `count` follows `data` and count edges are discarded.
- R7: If rising edges of `up` and `down` reach the edge detectors in the same cycle, `count` does not change.
- R8: `carry_n` is 0 exactly when `count` is at its maximum and the synchronized `up` level is 0. The synchronized level is `up` as sampled two edges earlier. Otherwise `carry_n` is 1.
- R9: `borrow_n` is 0 exactly when `count` is 0 and the synchronized `down` level is 0. Otherwise `borrow_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| mreset | input | 1 | Master reset, active high, asynchronous assertion |
| load_n | input | 1 | Parallel load, active low |
| data | input | WIDTH | Preset value |
| up | input | 1 | Count-up pulse input |
| down | input | 1 | Count-down pulse input |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low terminal count for counting up |
| borrow_n | output | 1 | Active-low terminal count for counting down |

## Verification
The bound checker checks these properties on every cycle:
- a reset holds the count at zero;
- a load captures `data`;
- outside a load, the count moves by at most one step in either direction;
- each terminal output asserts only at its own end value and follows the delayed level of its pulse input.

Some behaviours can be seen only in the bench's scenarios: pairs of colliding pulses cancelling, wrap-around in both directions, pulses arriving during a held load, and a reset landing mid-count. The bench compares every cycle against a behavioural model of the synchronizer delay.

// File: rtl/dual_pulse_counter_pkg.sv
package dual_pulse_counter_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;

  // Opposing requests cancel; a lone request selects its direction.
  function automatic step_e decode_step(input logic inc, input logic dec);
    if (inc && !dec) return STEP_INC;
    if (dec && !inc) return STEP_DEC;
    return STEP_HOLD;
  endfunction

endpackage

// File: rtl/pulse_edge_sync.sv
module pulse_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level,
  output logic rise
);
  localparam int LAST = STAGES;

  // Stages 0..STAGES-1 are the synchronizer; stage STAGES holds the previous level.
  logic [LAST:0] sh;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) sh <= '0;
    else     sh <= {sh[LAST-1:0], pin};
  end

  assign level = sh[LAST-1];
  assign rise  = sh[LAST-1] & ~sh[LAST];
endmodule

// File: rtl/count_core.sv
module count_core
  import dual_pulse_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_n,
  input  logic [WIDTH-1:0] data,
  input  logic             inc,
  input  logic             dec,
  output logic [WIDTH-1:0] cnt
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  step_e step;
  assign step = decode_step(inc, dec);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)          cnt <= '0;
    else if (!load_n) cnt <= data;
    else begin
      case (step)
        STEP_INC: cnt <= cnt + ONE;
        STEP_DEC: cnt <= cnt - ONE;
        default:  cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/term_detect.sv
module term_detect #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cnt,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP = '1;
  localparam logic [WIDTH-1:0] BOT = '0;

  assign carry_n  = ~((cnt == TOP) & ~up_lvl);
  assign borrow_n = ~((cnt == BOT) & ~dn_lvl);
endmodule

// File: rtl/dual_pulse_counter.sv
module dual_pulse_counter #(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             mreset,
  input  logic             load_n,
  input  logic [WIDTH-1:0] data,
  input  logic             up,
  input  logic             down,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam int NPULSE = 2;

  logic [NPULSE-1:0] pins, lvls, rises;
  assign pins = {down, up};

  genvar gi;
  generate
    for (gi = 0; gi < NPULSE; gi++) begin : g_sync
      pulse_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (mreset),
        .pin   (pins[gi]),
        .level (lvls[gi]),
        .rise  (rises[gi])
      );
    end
  endgenerate

  count_core #(.WIDTH(WIDTH)) u_core (
    .clk    (clk),
    .rst    (mreset),
    .load_n (load_n),
    .data   (data),
    .inc    (rises[0]),
    .dec    (rises[1]),
    .cnt    (count)
  );

  term_detect #(.WIDTH(WIDTH)) u_term (
    .cnt      (count),
    .up_lvl   (lvls[0]),
    .dn_lvl   (lvls[1]),
    .carry_n  (carry_n),
    .borrow_n (borrow_n)
  );
endmodule

// File: rtl/dual_pulse_counter_chk.sv
module dual_pulse_counter_chk #(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             mreset,
  input logic             load_n,
  input logic [WIDTH-1:0] data,
  input logic             up,
  input logic             down,
  input logic [WIDTH-1:0] count,
  input logic             carry_n,
  input logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP = '1;

  p_reset_zero_r1: assert property (@(posedge clk) mreset |-> count == '0);

  p_load_capture_r6: assert property (@(posedge clk) disable iff (mreset)
    !load_n |=> count == $past(data));

  // R2 R3 R4 R5: without a load, the count moves at most one step, wrapping.
  p_unit_step_r2: assert property (@(posedge clk) disable iff (mreset)
    load_n |=> (count == $past(count)) ||
               (count == WIDTH'($past(count) + 1'b1)) ||
               (count == WIDTH'($past(count) - 1'b1)));

  p_carry_at_top_r8: assert property (@(posedge clk) disable iff (mreset)
    !carry_n |-> count == TOP);

  p_borrow_at_zero_r9: assert property (@(posedge clk) disable iff (mreset)
    !borrow_n |-> count == '0);

  generate
    if (SYNC_STAGES == 2) begin : g_lvl
      p_carry_level_r8: assert property (@(posedge clk) disable iff (mreset)
        (!$past(mreset) && !$past(mreset, 2)) |->
          carry_n == !((count == TOP) && !$past(up, 2)));
      p_borrow_level_r9: assert property (@(posedge clk) disable iff (mreset)
        (!$past(mreset) && !$past(mreset, 2)) |->
          borrow_n == !((count == '0) && !$past(down, 2)));
    end
  endgenerate
endmodule

bind dual_pulse_counter dual_pulse_counter_chk #(
  .WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .mreset(mreset), .load_n(load_n), .data(data), .up(up),
  .down(down), .count(count), .carry_n(carry_n), .borrow_n(borrow_n)
);

// File: tb/dual_pulse_counter_bench.sv
module dual_pulse_counter_bench;
  localparam int W   = 4;
  localparam int MAX = (1 << W) - 1;

  logic         clk = 0;
  logic         mreset = 1;
  logic         load_n = 1;
  logic [W-1:0] data = '0;
  logic         up = 0;
  logic         down = 0;
  logic [W-1:0] count;
  logic         carry_n, borrow_n;

  int compared = 0;
  int mismatched = 0;
  string req = "R1";
  bit finished = 0;

  // Behavioural reference model.
  int m_cnt = 0;
  bit hu[3];
  bit hd[3];

  always #5 clk = ~clk;

  dual_pulse_counter #(.WIDTH(W), .SYNC_STAGES(2)) u_dual_pulse_counter (
    .clk(clk), .mreset(mreset), .load_n(load_n), .data(data), .up(up),
    .down(down), .count(count), .carry_n(carry_n), .borrow_n(borrow_n)
  );

  task automatic check(string r, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", r, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit eu, ed;
    if (mreset) begin
      m_cnt = 0;
      hu = '{0, 0, 0};
      hd = '{0, 0, 0};
    end else begin
      eu = hu[1] && !hu[2];
      ed = hd[1] && !hd[2];
      hu[2] = hu[1]; hu[1] = hu[0]; hu[0] = up;
      hd[2] = hd[1]; hd[1] = hd[0]; hd[0] = down;
      if (!load_n)        m_cnt = int'(data);
      else if (eu && !ed) m_cnt = (m_cnt + 1) % (MAX + 1);
      else if (ed && !eu) m_cnt = (m_cnt + MAX) % (MAX + 1);
    end
    #2;
    if (!finished) begin
      check(req, "count", int'(count), m_cnt);
      check((req == "R8") ? "R8" : {req, "/R8"}, "carry_n", int'(carry_n),
            (m_cnt == MAX && !hu[1]) ? 0 : 1);
      check((req == "R9") ? "R9" : {req, "/R9"}, "borrow_n", int'(borrow_n),
            (m_cnt == 0 && !hd[1]) ? 0 : 1);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(bit u, bit d);
    @(negedge clk); up = u; down = d;
    idle(3);
    up = 0; down = 0;
    idle(3);
  endtask

  initial begin
    idle(3);
    req = "R1";
    check("R1", "reset count", int'(count), 0);
    mreset = 0;
    idle(2);

    req = "R2";
    for (int i = 0; i < 5; i++) pulse(1, 0);
    check("R2", "after 5 ups", int'(count), 5);

    req = "R8";
    for (int i = 0; i < 10; i++) pulse(1, 0);
    check("R8", "carry low at top", int'(carry_n), 0);
    @(negedge clk); up = 1;
    idle(3);
    check("R8", "carry high while up high", int'(carry_n), 1);
    up = 0;
    idle(4);
    req = "R4";
    check("R4", "wrap to zero", int'(count), 0);

    req = "R9";
    check("R9", "borrow low at zero", int'(borrow_n), 0);
    @(negedge clk); down = 1;
    idle(3);
    check("R9", "borrow high while down high", int'(borrow_n), 1);
    down = 0;
    idle(4);
    req = "R5";
    check("R5", "wrap to max", int'(count), MAX);

    req = "R3";
    for (int i = 0; i < 3; i++) pulse(0, 1);
    check("R3", "after 3 downs", int'(count), MAX - 3);

    req = "R7";
    for (int i = 0; i < 3; i++) pulse(1, 1);
    check("R7", "cancelled pairs", int'(count), MAX - 3);

    req = "R6";
    @(negedge clk); data = 4'd9; load_n = 0;
    @(negedge clk);
    check("R6", "load captured", int'(count), 9);
    pulse(1, 0);
    check("R6", "up ignored during load", int'(count), 9);
    @(negedge clk); data = 4'd3;
    @(negedge clk);
    check("R6", "follows data", int'(count), 3);
    load_n = 1;
    pulse(1, 0);
    check("R6", "counts after load", int'(count), 4);

    req = "R1";
    @(negedge clk); up = 1;
    @(negedge clk); mreset = 1;
    #1;
    check("R1", "async clear mid-count", int'(count), 0);
    @(negedge clk); load_n = 0; data = 4'd7;
    @(negedge clk);
    check("R1", "reset over load", int'(count), 0);
    up = 0; load_n = 1;
    idle(2);
    mreset = 0;
    idle(2);
    pulse(1, 0);
    check("R1", "counts after reset", int'(count), 1);

    finished = 1;
    idle(1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule